// File: doc/BRIEF.md
# ATM Transmit Cell Processor

This block sits between the ATM layer and a TDM framer on the transmit side. Complete 53-byte cells arrive one byte per cycle and are held in a small cell buffer. The framer pulls octets one at a time. At every cell boundary the block sends the oldest complete buffered cell. If no complete cell is buffered, it sends a rate-decoupling cell instead, so the octet stream never stops.

On the way out, the fifth octet of each cell carries a header check byte: a CRC-8 over the four header octets with a coset value XORed in. A one-shot request can flip one bit of that byte. The 48 payload octets can pass through a self-synchronous scrambler. A saturating counter records how many buffered cells went out without a forced check-byte error.

Top module: `atm_tx_cell_proc`

## Requirements
- R1: `cfg_depth` sets how many complete cells the buffer holds: 2'b00 gives 2, 2'b01 gives 3, and 2'b10 or 2'b11 give 4 (limited to `MAX_CELLS`).
- R2: `room2` is high exactly when the depth, less the stored complete cells, less one for a cell being written, is at least 2.
- R3: A byte with `in_wr` and `in_soc` both high starts a cell at byte 0. The start is refused when the stored complete cells already equal the depth. A refused cell, and any `in_wr` byte outside an accepted cell, is discarded and never sent. An accepted cell is complete on its 53rd byte.
- R4: When the framer requests the first octet of a cell and no complete cell is stored, a decoupling cell is sent. Its header is 00 00 00 01 when `cfg_unassigned`=0 and 00 00 00 00 when it is 1. All 48 payload octets before scrambling equal `cfg_fill`.
- R5: Each `out_req` high at a clock edge produces one octet on `out_data`, with `out_valid` high, in the following cycle. `out_valid` is low otherwise. Stored cells leave in arrival order, and their header octets are sent unchanged.
- R6: Octet 4 (counting from 0) of a cell is CRC-8 (generator x^8+x^2+x+1, MSB first, initial value 0) over octets 0..3, XORed with `cfg_coset`. This applies to decoupling cells always, and to stored cells when `cfg_hec_en`=1. When `cfg_hec_en`=0, a stored cell's own octet 4 is sent.
- R7: An `err_inj` pulse inverts bit 0 of octet 4 in the next cell to start, and only in that cell.
- R8: When `cfg_scr_en`=1, each payload octet (octets 5..52) is scrambled MSB first: output bit = input bit XOR the output bit sent 43 bits earlier. The history starts at zero after reset, is not advanced by header octets, and is held while `cfg_scr_en`=0.
- R9: `tx_cell_count` is zero after reset. It increments when the last octet of a stored cell is sent without an injected error, and stays at its all-ones maximum once it reaches it. Decoupling cells never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_depth | input | 2 | Buffer depth select |
| cfg_unassigned | input | 1 | Decoupling header select: 1 unassigned, 0 idle |
| cfg_fill | input | 8 | Decoupling payload octet |
| cfg_hec_en | input | 1 | Insert computed check byte into stored cells |
| cfg_coset | input | 8 | Value XORed into the computed check byte |
| cfg_scr_en | input | 1 | Payload scrambler enable |
| err_inj | input | 1 | One-shot check-byte error request |
| in_wr | input | 1 | Input byte strobe |
| in_soc | input | 1 | Marks the first byte of a cell |
| in_data | input | 8 | Input cell byte |
| room2 | output | 1 | Buffer has space for at least two more cells |
| out_req | input | 1 | Framer octet request |
| out_valid | output | 1 | Octet on out_data is valid |
| out_data | output | 8 | Transmitted octet |
| tx_cell_count | output | CNT_W | Saturating count of good stored cells sent |

## Verification
The assertions assume that `cfg_depth` stays fixed while any cell is stored or being written. They also assume the remaining configuration changes only between cells, and that `err_inj` is a single-cycle pulse. The stimulus changes configuration only after the framer has drained the buffer and no write is in progress. It writes cells only while the framer is idle, so the decision between a stored and a decoupling cell at each boundary is known in advance. Requests are issued both back to back and with idle cycles between them, which exercises the octet sequencing under both request patterns.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;
  localparam int CELL_BYTES = 53;
  localparam int HDR_BYTES  = 4;
  localparam int HEC_POS    = 4;
  localparam int SCR_LEN    = 43;
  localparam int IDX_W      = 6;
  localparam logic [7:0] HEC_GEN = 8'h07;

  // One octet of CRC-8, MSB first
  function automatic logic [7:0] hec_step(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      if (c[7] ^ b[i]) c = {c[6:0], 1'b0} ^ HEC_GEN;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  // The tap lies 43 bits back, beyond the 8 bits of one octet,
  // so a whole octet is scrambled at once
  function automatic logic [7:0] scr_byte(input logic [SCR_LEN-1:0] hist, input logic [7:0] d);
    return d ^ hist[SCR_LEN-1 -: 8];
  endfunction

  function automatic logic [SCR_LEN-1:0] scr_shift(input logic [SCR_LEN-1:0] hist, input logic [7:0] o);
    return {hist[SCR_LEN-9:0], o};
  endfunction
endpackage

// File: rtl/atm_tx_cell_fifo.sv
module atm_tx_cell_fifo
  import atm_tx_pkg::*;
#(
  parameter int MAX_CELLS = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [$clog2(MAX_CELLS+1):0]         depth_cells,
  input  logic                                 wr_en,
  input  logic                                 wr_soc,
  input  logic [7:0]                           wr_data,
  input  logic [IDX_W-1:0]                     rd_idx,
  input  logic                                 pop,
  output logic [7:0]                           rd_data,
  output logic [$clog2(MAX_CELLS+1):0]         cells_stored,
  output logic                                 wr_busy,
  output logic                                 drop_ev
);
  localparam int SLOT_W    = (MAX_CELLS > 1) ? $clog2(MAX_CELLS) : 1;
  localparam int CW        = $clog2(MAX_CELLS+1) + 1;
  localparam int MEM_BYTES = MAX_CELLS * CELL_BYTES;
  localparam int AW        = $clog2(MEM_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  logic [7:0]        mem [MEM_BYTES];
  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic [IDX_W-1:0]  wr_idx, wr_pos;
  logic              wr_active;
  logic [CW-1:0]     cells_q;
  logic              accept_start, byte_we, last_byte;

  function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] s,
                                                  input logic [CW-1:0] d);
    if (CW'(s) + CW'(1) == d) return '0;
    return s + SLOT_W'(1);
  endfunction

  function automatic logic [AW-1:0] byte_addr(input logic [SLOT_W-1:0] s,
                                              input logic [IDX_W-1:0] i);
    return AW'(s) * AW'(CELL_BYTES) + AW'(i);
  endfunction

  assign accept_start = wr_en && wr_soc && (cells_q < depth_cells);
  assign drop_ev      = wr_en && wr_soc && !accept_start;
  assign byte_we      = accept_start || (wr_en && !wr_soc && wr_active);
  assign wr_pos       = accept_start ? '0 : wr_idx;
  assign last_byte    = byte_we && (wr_pos == LAST_IDX);

  always_ff @(posedge clk) begin
    if (byte_we) mem[byte_addr(wr_slot, wr_pos)] <= wr_data;
  end

  assign rd_data = mem[byte_addr(rd_slot, rd_idx)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_active <= 1'b0;
      wr_idx    <= '0;
      wr_slot   <= '0;
    end else if (drop_ev) begin
      wr_active <= 1'b0;
      wr_idx    <= '0;
    end else if (byte_we) begin
      if (last_byte) begin
        wr_active <= 1'b0;
        wr_idx    <= '0;
        wr_slot   <= next_slot(wr_slot, depth_cells);
      end else begin
        wr_active <= 1'b1;
        wr_idx    <= wr_pos + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_slot <= '0;
      cells_q <= '0;
    end else begin
      if (pop) rd_slot <= next_slot(rd_slot, depth_cells);
      case ({last_byte, pop})
        2'b10:   cells_q <= cells_q + CW'(1);
        2'b01:   cells_q <= cells_q - CW'(1);
        default: cells_q <= cells_q;
      endcase
    end
  end

  assign cells_stored = cells_q;
  assign wr_busy      = wr_active;
endmodule

// File: rtl/atm_tx_scrambler.sv
module atm_tx_scrambler
  import atm_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       step,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [SCR_LEN-1:0] hist;

  assign dout = enable ? scr_byte(hist, din) : din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hist <= '0;
    else if (step && enable) hist <= scr_shift(hist, dout);
  end
endmodule

// File: rtl/atm_tx_cell_proc.sv
module atm_tx_cell_proc
  import atm_tx_pkg::*;
#(
  parameter int MAX_CELLS = 4,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_depth,
  input  logic             cfg_unassigned,
  input  logic [7:0]       cfg_fill,
  input  logic             cfg_hec_en,
  input  logic [7:0]       cfg_coset,
  input  logic             cfg_scr_en,
  input  logic             err_inj,
  input  logic             in_wr,
  input  logic             in_soc,
  input  logic [7:0]       in_data,
  output logic             room2,
  input  logic             out_req,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic [CNT_W-1:0] tx_cell_count
);
  localparam int CW = $clog2(MAX_CELLS+1) + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);
  localparam logic [IDX_W-1:0] HEC_IDX  = IDX_W'(HEC_POS);
  localparam logic [IDX_W-1:0] HDR_END  = IDX_W'(HDR_BYTES);

  logic [CW-1:0]    depth_cells, cells_stored, depth_raw;
  logic             wr_busy, drop_ev;
  logic [7:0]       fifo_rd;
  logic [IDX_W-1:0] rd_idx;
  logic             cur_assigned, cur_inj, inj_pending;
  logic [7:0]       crc_q;
  logic             out_valid_q;
  logic [7:0]       out_data_q;
  logic [CNT_W-1:0] cnt_q;

  // named internal events, also used by the checker
  logic       at_start, cell_start, cell_end, pop, good_cell;
  logic       send_assigned, send_inj, in_header, in_payload, scr_step;
  logic [7:0] dec_byte, src_byte, hec_out, scr_dout, next_byte;

  always_comb begin
    case (cfg_depth)
      2'b00:   depth_raw = CW'(2);
      2'b01:   depth_raw = CW'(3);
      default: depth_raw = CW'(4);
    endcase
    depth_cells = (depth_raw > CW'(MAX_CELLS)) ? CW'(MAX_CELLS) : depth_raw;
  end

  assign room2 = ({1'b0, depth_cells} >= ({1'b0, cells_stored} + (CW+1)'(wr_busy) + (CW+1)'(2)));

  atm_tx_cell_fifo #(.MAX_CELLS(MAX_CELLS)) u_fifo (
    .clk          (clk),
    .rst_n        (rst_n),
    .depth_cells  (depth_cells),
    .wr_en        (in_wr),
    .wr_soc       (in_soc),
    .wr_data      (in_data),
    .rd_idx       (rd_idx),
    .pop          (pop),
    .rd_data      (fifo_rd),
    .cells_stored (cells_stored),
    .wr_busy      (wr_busy),
    .drop_ev      (drop_ev)
  );

  assign at_start      = (rd_idx == '0);
  assign cell_start    = out_req && at_start;
  assign cell_end      = out_req && (rd_idx == LAST_IDX);
  assign send_assigned = at_start ? (cells_stored != '0) : cur_assigned;
  assign send_inj      = at_start ? inj_pending : cur_inj;
  assign in_header     = (rd_idx < HDR_END);
  assign in_payload    = (rd_idx > HEC_IDX);
  assign scr_step      = out_req && in_payload;
  assign pop           = cell_end && cur_assigned;
  assign good_cell     = pop && !cur_inj;

  assign dec_byte = in_header ? ((rd_idx == IDX_W'(3) && !cfg_unassigned) ? 8'h01 : 8'h00)
                              : cfg_fill;
  assign src_byte = send_assigned ? fifo_rd : dec_byte;
  assign hec_out  = (((!send_assigned || cfg_hec_en) ? (crc_q ^ cfg_coset) : src_byte))
                    ^ {7'b0, send_inj};

  atm_tx_scrambler u_scr (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (cfg_scr_en),
    .step   (scr_step),
    .din    (src_byte),
    .dout   (scr_dout)
  );

  assign next_byte = in_header ? src_byte : ((rd_idx == HEC_IDX) ? hec_out : scr_dout);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx       <= '0;
      cur_assigned <= 1'b0;
      cur_inj      <= 1'b0;
      crc_q        <= '0;
      out_valid_q  <= 1'b0;
      out_data_q   <= '0;
    end else begin
      out_valid_q <= out_req;
      if (out_req) begin
        out_data_q <= next_byte;
        rd_idx     <= (rd_idx == LAST_IDX) ? '0 : rd_idx + IDX_W'(1);
        if (at_start) begin
          cur_assigned <= send_assigned;
          cur_inj      <= inj_pending;
          crc_q        <= hec_step(8'h00, src_byte);
        end else if (in_header) begin
          crc_q <= hec_step(crc_q, src_byte);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      inj_pending <= 1'b0;
    else if (err_inj) inj_pending <= 1'b1;
    else if (cell_start) inj_pending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (good_cell && !(&cnt_q)) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign out_valid     = out_valid_q;
  assign out_data      = out_data_q;
  assign tx_cell_count = cnt_q;
endmodule

// File: rtl/atm_tx_cell_proc_chk.sv
module atm_tx_cell_proc_chk #(
  parameter int CNT_W = 16,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_req,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic [CNT_W-1:0] tx_cell_count,
  input logic [CW-1:0]    cells_stored,
  input logic [CW-1:0]    depth_cells,
  input logic             drop_ev,
  input logic             pop,
  input logic             good_cell,
  input logic             cell_start,
  input logic             err_inj,
  input logic             inj_pending,
  input logic [5:0]       rd_idx,
  input logic             send_assigned,
  input logic [7:0]       fifo_rd
);
  // R5
  valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |=> out_valid);
  // R5
  no_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_req |=> !out_valid);
  // R1
  stored_within_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cells_stored <= depth_cells);
  // R3
  drop_keeps_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_ev && !pop) |=> (cells_stored == $past(cells_stored)));
  // R4
  decoupling_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && rd_idx < 6'd3 && !send_assigned) |=> (out_data == 8'h00));
  // R5
  stored_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && rd_idx < 6'd4 && send_assigned) |=> (out_data == $past(fifo_rd)));
  // R7
  inj_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_start && !err_inj) |=> !inj_pending);
  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good_cell |=> ((tx_cell_count == $past(tx_cell_count) + CNT_W'(1)) || (&tx_cell_count)));
  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !good_cell |=> $stable(tx_cell_count));
endmodule

bind atm_tx_cell_proc atm_tx_cell_proc_chk #(.CNT_W(CNT_W), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .out_req       (out_req),
  .out_valid     (out_valid),
  .out_data      (out_data),
  .tx_cell_count (tx_cell_count),
  .cells_stored  (cells_stored),
  .depth_cells   (depth_cells),
  .drop_ev       (drop_ev),
  .pop           (pop),
  .good_cell     (good_cell),
  .cell_start    (cell_start),
  .err_inj       (err_inj),
  .inj_pending   (inj_pending),
  .rd_idx        (rd_idx),
  .send_assigned (send_assigned),
  .fifo_rd       (fifo_rd)
);

// File: tb/atm_tx_cell_proc_tb.sv
`timescale 1ns/1ps
module atm_tx_cell_proc_tb;
  localparam int CW_T = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_depth = 2'b10;
  logic cfg_unassigned = 1'b0;
  logic [7:0] cfg_fill = 8'h6A;
  logic cfg_hec_en = 1'b1;
  logic [7:0] cfg_coset = 8'h55;
  logic cfg_scr_en = 1'b0;
  logic err_inj = 1'b0;
  logic in_wr = 1'b0, in_soc = 1'b0;
  logic [7:0] in_data = '0;
  logic room2, out_req = 1'b0, out_valid;
  logic [7:0] out_data;
  logic [CW_T-1:0] tx_cell_count;

  always #2.5 clk = ~clk;

  atm_tx_cell_proc #(.MAX_CELLS(4), .CNT_W(CW_T)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_unassigned(cfg_unassigned),
    .cfg_fill(cfg_fill), .cfg_hec_en(cfg_hec_en), .cfg_coset(cfg_coset),
    .cfg_scr_en(cfg_scr_en), .err_inj(err_inj), .in_wr(in_wr), .in_soc(in_soc),
    .in_data(in_data), .room2(room2), .out_req(out_req), .out_valid(out_valid),
    .out_data(out_data), .tx_cell_count(tx_cell_count)
  );

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] stored_q[$];
  logic [42:0] m_hist = '0;
  bit m_inj = 0;
  int exp_cnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int depth_of(input logic [1:0] c);
    return (c == 2'b00) ? 2 : (c == 2'b01) ? 3 : 4;
  endfunction

  // long division of header * x^8 by 0x107
  function automatic logic [7:0] m_hec(input logic [31:0] h);
    logic [39:0] r;
    r = {h, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
    return r[7:0];
  endfunction

  // predicts the next cell on the line and queues its octets
  task automatic model_cell();
    logic [7:0] cb [53];
    bit asg;
    logic o;
    asg = (stored_q.size() >= 53);
    for (int i = 0; i < 53; i++) begin
      if (asg) cb[i] = stored_q.pop_front();
      else if (i < 4) cb[i] = (i == 3 && !cfg_unassigned) ? 8'h01 : 8'h00;
      else cb[i] = cfg_fill;
    end
    if (!asg || cfg_hec_en) cb[4] = m_hec({cb[0], cb[1], cb[2], cb[3]}) ^ cfg_coset;
    if (m_inj) cb[4][0] = ~cb[4][0];
    if (cfg_scr_en)
      for (int i = 5; i < 53; i++)
        for (int b = 7; b >= 0; b--) begin
          o = cb[i][b] ^ m_hist[42];
          m_hist = {m_hist[41:0], o};
          cb[i][b] = o;
        end
    for (int i = 0; i < 53; i++) begin
      exp_q.push_back(cb[i]);
      if (i < 4) tag_q.push_back(asg ? "R5 stored header" : "R4 decoupling header");
      else if (i == 4) tag_q.push_back(m_inj ? "R7 injected check byte" : "R6 check byte");
      else if (cfg_scr_en) tag_q.push_back("R8 scrambled payload");
      else tag_q.push_back(asg ? "R5 stored payload" : "R4 fill payload");
    end
    if (asg && !m_inj && exp_cnt < 7) exp_cnt++;
    m_inj = 0;
  endtask

  task automatic write_cell(input logic [7:0] seed);
    bit acc;
    logic [7:0] b;
    acc = (stored_q.size() / 53) < depth_of(cfg_depth);
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      b = (i < 4) ? seed + 8'(i) : (i == 4) ? 8'hC3 : seed ^ 8'(i * 7);
      in_wr = 1'b1;
      in_soc = (i == 0);
      in_data = b;
      if (acc) stored_q.push_back(b);
    end
    @(negedge clk);
    in_wr = 1'b0;
    in_soc = 1'b0;
  endtask

  task automatic pull(input int n, input bit gap);
    for (int c = 0; c < n; c++) model_cell();
    for (int k = 0; k < n * 53; k++) begin
      @(negedge clk);
      out_req = 1'b1;
      if (gap) begin
        @(negedge clk);
        out_req = 1'b0;
      end
    end
    @(negedge clk);
    out_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all predicted octets delivered", exp_q.size(), 0);
  endtask

  task automatic inject();
    @(negedge clk);
    err_inj = 1'b1;
    @(negedge clk);
    err_inj = 1'b0;
    m_inj = 1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected octet", out_data, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_data == e, t, out_data, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R5 reset valid", out_valid, 0);
    chk(tx_cell_count == 0, "R9 reset count", tx_cell_count, 0);
    chk(room2 == 1'b1, "R2 reset room", room2, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // idle decoupling cell, back-to-back requests
    pull(1, 0);
    // unassigned decoupling with scrambling, gapped requests
    cfg_unassigned = 1'b1;
    cfg_fill = 8'hA5;
    cfg_scr_en = 1'b1;
    pull(1, 1);

    // R1 R3: depth 2, third cell refused
    cfg_depth = 2'b00;
    @(negedge clk);
    chk(room2 == 1'b1, "R2 depth2 empty", room2, 1);
    write_cell(8'h10);
    chk(room2 == 1'b0, "R2 depth2 one cell", room2, 0);
    write_cell(8'h20);
    write_cell(8'h30);
    chk(room2 == 1'b0, "R2 depth2 full", room2, 0);
    pull(3, 0);
    chk(tx_cell_count == 3'(exp_cnt), "R3 R9 count after depth2", tx_cell_count, exp_cnt);
    chk(room2 == 1'b1, "R2 drained", room2, 1);

    // R7: injected error on a stored cell, next cell clean
    cfg_depth = 2'b11;
    write_cell(8'h40);
    inject();
    pull(2, 0);
    chk(tx_cell_count == 3'(exp_cnt), "R7 R9 injected not counted", tx_cell_count, exp_cnt);

    // R6: check byte insertion off, user octet passes
    cfg_hec_en = 1'b0;
    cfg_scr_en = 1'b0;
    write_cell(8'h55);
    pull(1, 1);
    cfg_hec_en = 1'b1;

    // R1: depth 3, fourth cell refused
    cfg_depth = 2'b01;
    cfg_scr_en = 1'b1;
    write_cell(8'h60);
    chk(room2 == 1'b1, "R2 depth3 one cell", room2, 1);
    write_cell(8'h70);
    chk(room2 == 1'b0, "R2 depth3 two cells", room2, 0);
    write_cell(8'h80);
    write_cell(8'h90);
    pull(4, 0);
    chk(tx_cell_count == 3'(exp_cnt), "R1 count after depth3", tx_cell_count, exp_cnt);

    // R9: saturation
    cfg_depth = 2'b10;
    for (int c = 0; c < 4; c++) write_cell(8'(8'hA0 + c * 16));
    pull(4, 0);
    chk(tx_cell_count == 3'd7, "R9 saturated", tx_cell_count, 7);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule